// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block makes the automatic RTS/CTS hardware flow control decisions for one UART channel. It sits beside a 16-byte receive FIFO and a transmit state machine. It takes two enable bits from an enhanced feature register, the receive FIFO fill count and a 2-bit receive trigger-level code. From these it drives the RTS pin and raises a receive-threshold interrupt request. It also gates the transmitter's permission to begin its next character, based on a synchronised copy of the CTS pin.

On the receive side, RTS uses hysteresis between neighbouring trigger levels. The pin goes high (stop sending) once the fill count reaches the trigger level above the programmed one. It goes low again only after the fill count falls below the trigger level beneath the programmed one. When automatic RTS is off, the pin carries the inverse of a software modem-control bit. On the transmit side, a high CTS stops new characters. A character already being shifted out is allowed to finish.

Top module: `uart_hwflow_ctrl`

## Requirements
- R1: After reset, tx_start_ok_o is 1 and rx_thr_irq_o is 0. With both enables clear, rts_pin_o equals the inverse of mcr_rts_i.
- R2: Only bit 7 (automatic CTS) and bit 6 (automatic RTS) of feat_reg_i have any effect. The other six bits are ignored.
- R3: With bit 7 set and tx_busy_i low, a change of cts_pin_i reaches tx_start_ok_o on the third rising edge. The output is the inverse of the pin level: CTS at 1 halts, CTS at 0 resumes.
- R4: While tx_busy_i is high, tx_start_ok_o holds its value. A pending change takes effect on the first rising edge at which tx_busy_i is low.
- R5: With bit 7 clear, tx_start_ok_o is 1 from the first rising edge at which tx_busy_i is low, whatever cts_pin_i does.
- R6: The trigger-level code rx_trig_sel_i selects a level of 1, 4, 8 or 14 bytes for codes 0, 1, 2 and 3. The level above 14 is 16. The level below 1 is 0.
- R7: One rising edge after the inputs are presented, rx_thr_irq_o is 1 exactly when bit 6 is set and rx_fill_i is at least the selected level.
- R8: With bit 6 set, rts_pin_o becomes 1 one rising edge after rx_fill_i reaches the level above the selected one.
- R9: With bit 6 set, rts_pin_o returns to 0 one rising edge after rx_fill_i is below the level beneath the selected one. For code 0 this means rx_fill_i equals 0. Between the two thresholds the pin holds its value.
- R10: With bit 6 clear, rts_pin_o is the inverse of mcr_rts_i and the automatic state is cleared, so setting bit 6 starts with rts_pin_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_reg_i | input | 8 | Enhanced feature register; bit 7 enables automatic CTS, bit 6 enables automatic RTS |
| mcr_rts_i | input | 1 | Software RTS bit from the modem-control register |
| cts_pin_i | input | 1 | Asynchronous CTS pin; 1 means stop sending |
| tx_busy_i | input | 1 | Transmitter is shifting out a character |
| rx_fill_i | input | 5 | Receive FIFO fill count, 0 to 16 |
| rx_trig_sel_i | input | 2 | Receive trigger-level code |
| tx_start_ok_o | output | 1 | Transmitter may start the next character |
| rts_pin_o | output | 1 | RTS pin level |
| rx_thr_irq_o | output | 1 | Receive-threshold interrupt request |

## Verification
Each result has a fixed latency. rx_thr_irq_o and the automatic RTS level follow one rising edge after the fill count or level code changes. tx_start_ok_o follows a CTS change after three edges: two synchroniser stages and the boundary register. It follows the fall of tx_busy_i after one edge. The software RTS path is combinational. The bench drives inputs on falling edges and samples on a later falling edge after exactly the number of rising edges due. For the CTS path it also samples one edge early to confirm the output has not yet moved. The receive side is checked by sweeping the fill count up from 0 to 16 and back down for every level code, comparing against thresholds the bench computes itself.

// File: rtl/uart_hwflow_pkg.sv
// Package: shared sizes and trigger-level arithmetic for the flow control unit.
// Assumes a receive FIFO of RX_DEPTH entries and four selectable trigger levels.
package uart_hwflow_pkg;
    localparam int RX_DEPTH  = 16;
    localparam int FILL_W    = $clog2(RX_DEPTH + 1);
    localparam int SEL_W     = 2;
    localparam int AUTO_CTS_BIT = 7;
    localparam int AUTO_RTS_BIT = 6;

    typedef logic [FILL_W-1:0] fill_t;

    // Programmed level for a code.
    function automatic fill_t trig_level(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    return fill_t'(1);
            2'd1:    return fill_t'(4);
            2'd2:    return fill_t'(8);
            default: return fill_t'(14);
        endcase
    endfunction

    // Level one step above the programmed one; the top step is a full FIFO.
    function automatic fill_t level_above(input logic [SEL_W-1:0] sel);
        if (sel == {SEL_W{1'b1}}) return fill_t'(RX_DEPTH);
        return trig_level(sel + 1'b1);
    endfunction

    // Level one step below the programmed one; the bottom step is empty.
    function automatic fill_t level_below(input logic [SEL_W-1:0] sel);
        if (sel == '0) return '0;
        return trig_level(sel - 1'b1);
    endfunction
endpackage

// File: rtl/uart_hwflow_cts_gate.sv
// CTS gate: synchronises the CTS pin and produces the transmit start permission.
// Assumes the permission is consumed only when the transmitter is idle; the
// halt flag is only updated at character boundaries (tx_busy_i low).
module uart_hwflow_cts_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_pin_i,
    input  logic tx_busy_i,
    output logic tx_start_ok_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   halt_q;

    // Synchroniser chain for the asynchronous CTS pin.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= cts_pin_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_pin_i};
            end
        end
    endgenerate

    // Halt decision sampled only between characters.
    always_ff @(posedge clk) begin
        if (!rst_n)          halt_q <= 1'b0;
        else if (!tx_busy_i) halt_q <= auto_en && sync_q[SYNC_STAGES-1];
    end

    assign tx_start_ok_o = !halt_q;
endmodule

// File: rtl/uart_hwflow_level_dec.sv
// Level decoder: compares the receive fill count with the programmed,
// upper and lower trigger levels. Purely combinational.
module uart_hwflow_level_dec
    import uart_hwflow_pkg::*;
(
    input  fill_t            fill_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             at_trig_o,
    output logic             at_upper_o,
    output logic             below_lower_o
);
    fill_t lvl_trig, lvl_up, lvl_dn;

    // Resolve the three thresholds and compare against the fill count.
    always_comb begin
        lvl_trig      = trig_level(sel_i);
        lvl_up        = level_above(sel_i);
        lvl_dn        = level_below(sel_i);
        at_trig_o     = fill_i >= lvl_trig;
        at_upper_o    = fill_i >= lvl_up;
        below_lower_o = (lvl_dn == '0) ? (fill_i == '0) : (fill_i < lvl_dn);
    end
endmodule

// File: rtl/uart_hwflow_rts_ctrl.sv
// RTS controller: holds the automatic RTS hysteresis state, registers the
// receive-threshold request and selects the RTS pin source.
// Assumes the threshold flags come from uart_hwflow_level_dec.
module uart_hwflow_rts_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic mcr_rts_i,
    input  logic at_trig_i,
    input  logic at_upper_i,
    input  logic below_lower_i,
    output logic rts_pin_o,
    output logic thr_irq_o
);
    logic stop_q;

    // Hysteresis state: set at the upper level, clear below the lower level.
    always_ff @(posedge clk) begin
        if (!rst_n || !auto_en) stop_q <= 1'b0;
        else if (at_upper_i)    stop_q <= 1'b1;
        else if (below_lower_i) stop_q <= 1'b0;
    end

    // Receive-threshold request, only while automatic RTS is on.
    always_ff @(posedge clk) begin
        if (!rst_n) thr_irq_o <= 1'b0;
        else        thr_irq_o <= auto_en && at_trig_i;
    end

    // Pin source: automatic state or inverted software bit.
    assign rts_pin_o = auto_en ? stop_q : !mcr_rts_i;
endmodule

// File: rtl/uart_hwflow_ctrl.sv
// Top: automatic RTS/CTS flow control for one UART channel.
// Assumes rx_fill_i never exceeds the FIFO depth and cts_pin_i is asynchronous.
module uart_hwflow_ctrl
    import uart_hwflow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       feat_reg_i,
    input  logic             mcr_rts_i,
    input  logic             cts_pin_i,
    input  logic             tx_busy_i,
    input  logic [FILL_W-1:0] rx_fill_i,
    input  logic [SEL_W-1:0] rx_trig_sel_i,
    output logic             tx_start_ok_o,
    output logic             rts_pin_o,
    output logic             rx_thr_irq_o
);
    logic cts_en, rts_en;
    logic at_trig, at_upper, below_lower;

    assign cts_en = feat_reg_i[AUTO_CTS_BIT];
    assign rts_en = feat_reg_i[AUTO_RTS_BIT];

    uart_hwflow_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_en       (cts_en),
        .cts_pin_i     (cts_pin_i),
        .tx_busy_i     (tx_busy_i),
        .tx_start_ok_o (tx_start_ok_o)
    );

    uart_hwflow_level_dec u_dec (
        .fill_i        (rx_fill_i),
        .sel_i         (rx_trig_sel_i),
        .at_trig_o     (at_trig),
        .at_upper_o    (at_upper),
        .below_lower_o (below_lower)
    );

    uart_hwflow_rts_ctrl u_rts (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_en       (rts_en),
        .mcr_rts_i     (mcr_rts_i),
        .at_trig_i     (at_trig),
        .at_upper_i    (at_upper),
        .below_lower_i (below_lower),
        .rts_pin_o     (rts_pin_o),
        .thr_irq_o     (rx_thr_irq_o)
    );
endmodule

// File: rtl/uart_hwflow_ctrl_chk.sv
// Checker: temporal properties of the flow control unit, bound to the top.
module uart_hwflow_ctrl_chk
    import uart_hwflow_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       feat_reg_i,
    input logic             tx_busy_i,
    input logic [FILL_W-1:0] rx_fill_i,
    input logic [SEL_W-1:0] rx_trig_sel_i,
    input logic             tx_start_ok_o,
    input logic             rts_pin_o,
    input logic             rx_thr_irq_o
);
    logic en_cts, en_rts;
    assign en_cts = feat_reg_i[7];
    assign en_rts = feat_reg_i[6];

    assert_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy_i |=> $stable(tx_start_ok_o));

    assert_cts_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy_i && !en_cts) |=> tx_start_ok_o);

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rts && rx_fill_i >= trig_level(rx_trig_sel_i)) |=> rx_thr_irq_o);

    assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rts |=> !rx_thr_irq_o);

    assert_rts_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rts && rx_fill_i >= level_above(rx_trig_sel_i)) |=> (!en_rts || rts_pin_o));

    assert_rts_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rts && rx_fill_i == '0) |=> (!en_rts || !rts_pin_o));

    assert_rts_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_rts) |-> !rts_pin_o);
endmodule

bind uart_hwflow_ctrl uart_hwflow_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .feat_reg_i    (feat_reg_i),
    .tx_busy_i     (tx_busy_i),
    .rx_fill_i     (rx_fill_i),
    .rx_trig_sel_i (rx_trig_sel_i),
    .tx_start_ok_o (tx_start_ok_o),
    .rts_pin_o     (rts_pin_o),
    .rx_thr_irq_o  (rx_thr_irq_o)
);

// File: tb/uart_hwflow_ctrl_tb.sv
module uart_hwflow_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] feat = 8'h00;
    logic       mcr = 1'b0;
    logic       cts = 1'b0;
    logic       busy = 1'b0;
    logic [4:0] fill = 5'd0;
    logic [1:0] sel = 2'd0;
    logic       ok, rts, irq;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = !clk;

    uart_hwflow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .feat_reg_i(feat), .mcr_rts_i(mcr),
        .cts_pin_i(cts), .tx_busy_i(busy), .rx_fill_i(fill),
        .rx_trig_sel_i(sel), .tx_start_ok_o(ok), .rts_pin_o(rts),
        .rx_thr_irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int lvl(input int s);
        case (s)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int hold;
        edges(3);
        rst_n = 1'b1;
        edges(1);
        // R1 reset state
        chk("R1 ok", ok, 1);
        chk("R1 irq", irq, 0);
        chk("R1 rts", rts, 1);
        // R10 software path: pin is inverse of the bit, fill has no effect
        for (int m = 0; m < 2; m++) begin
            mcr = m[0]; fill = 5'd16;
            edges(1);
            chk("R10 rts sw", rts, 1 - m);
            chk("R7 irq disabled", irq, 0);
        end
        fill = 0;
        // R2: other feature bits have no effect
        feat = 8'h3F; cts = 1'b1; fill = 5'd16;
        edges(4);
        chk("R2 ok", ok, 1);
        chk("R2 irq", irq, 0);
        chk("R2 rts", rts, 0);
        // R5: CTS high without enable
        feat = 8'h00;
        edges(4);
        chk("R5 ok", ok, 1);
        fill = 0; cts = 1'b0;
        edges(3);
        // R3: halt and resume latency
        feat = 8'h80; cts = 1'b1;
        edges(2);
        chk("R3 halt early", ok, 1);
        edges(1);
        chk("R3 halt", ok, 0);
        cts = 1'b0;
        edges(2);
        chk("R3 resume early", ok, 0);
        edges(1);
        chk("R3 resume", ok, 1);
        // R4: busy holds permission, first idle edge applies it
        busy = 1'b1; cts = 1'b1;
        edges(5);
        chk("R4 held", ok, 1);
        busy = 1'b0;
        edges(1);
        chk("R4 boundary", ok, 0);
        busy = 1'b1; feat = 8'h00;
        edges(3);
        chk("R4 held off", ok, 0);
        busy = 1'b0;
        edges(1);
        chk("R5 released", ok, 1);
        cts = 1'b0;
        edges(3);
        // R6..R9 sweep every level code with automatic RTS
        mcr = 1'b1;
        feat = 8'h40;
        edges(1);
        chk("R10 enable starts low", rts, 0);
        for (int s = 0; s < 4; s++) begin
            int up, dn;
            sel = s[1:0];
            up = (s == 3) ? 16 : lvl(s + 1);
            dn = (s == 0) ? 0 : lvl(s - 1);
            hold = 0;
            fill = 0;
            edges(1);
            for (int k = 0; k < 34; k++) begin
                int f;
                f = (k < 17) ? k : 33 - k;
                fill = f[4:0];
                edges(1);
                if (f >= up) hold = 1;
                else if ((dn == 0) ? (f == 0) : (f < dn)) hold = 0;
                chk("R6 R7 irq", irq, (f >= lvl(s)) ? 1 : 0);
                chk("R8 R9 rts", rts, hold);
            end
        end
        // R10: disabling clears state
        fill = 5'd16;
        edges(1);
        chk("R8 full", rts, 1);
        feat = 8'h00; mcr = 1'b1;
        edges(1);
        chk("R10 sw after auto", rts, 0);
        fill = 5'd10;
        feat = 8'h40;
        #1;
        chk("R10 re-enable", rts, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule